// File: doc/BRIEF.md
# Instruction Control Decoder for a 32-bit RISC Subset

This block turns one 32-bit instruction word into the control bundle a single-issue datapath needs. It covers a fixed set of operations: register-register arithmetic, logic and compares, immediate arithmetic and logic, constant-amount shifts, word loads and stores, conditional branches, direct and register jumps, a call that saves its return address, a system-call trap, and the coprocessor-0 moves and exception return. It has no clock and no state. The outputs follow the instruction word within the same cycle.

The datapath reads the control bundle to steer its operand multiplexers, the ALU, the register write-back port, the data memory, the next-PC logic and the coprocessor-0 unit. Any word outside the subset sets `illegal_o`. When that happens, every strobe that could change architectural state is held low, so the datapath can raise a reserved-instruction exception without having to cancel any side effect.

Top module: `insn_ctrl_decode`

## Requirements
- R1: With opcode 0x00, these funct values select an ALU code: add 0x20 and addu 0x21 give 0, sub 0x22 gives 1, and 0x24 gives 2, or 0x25 gives 3, nor 0x27 gives 4, slt 0x2A gives 5, sltu 0x2B gives 6. Each of them sets `reg_wr_o` with `reg_dst_o`=1 (rd) and `alu_src_imm_o`=0.
- R2: With opcode 0x00, these funct values are shifts: sll 0x00 gives ALU code 7, srl 0x02 gives 8, sra 0x03 gives 9. Each sets `shamt_src_o`=1, `reg_wr_o`=1 and `reg_dst_o`=1, and the shifted operand is rt. The all-zero word decodes as sll.
- R3: These opcodes set `alu_src_imm_o`=1, `reg_wr_o`=1 and `reg_dst_o`=0 (rt): addi 0x08 and addiu 0x09 give ALU code 0, slti 0x0A gives 5, andi 0x0C gives 2, ori 0x0D gives 3.
- R4: `sign_ext_o` is 0 only for andi and ori, which zero-extend their immediate. It is 1 for every other word, including addi, addiu, slti, loads, stores, branches and illegal words.
- R5: lw 0x23 sets `mem_rd_o`, `reg_wr_o`, `reg_dst_o`=0, `alu_src_imm_o` and ALU code 0. sw 0x2B sets `mem_wr_o`, `alu_src_imm_o` and ALU code 0, with no register write.
- R6: beq 0x04 sets `branch_o`=1 and bne 0x05 sets `branch_o`=2. Both use ALU code 1 with `alu_src_imm_o`=0 and do not write a register.
- R7: j 0x02 sets `jump_o`=1. jal 0x03 sets `jump_o`=1, `link_o`=1, `reg_wr_o`=1 and `reg_dst_o`=2 (register 31). jr (opcode 0x00, funct 0x08) sets `jump_o`=2 and writes nothing.
- R8: `ovf_trap_o` is 1 for add, sub and addi only. It is 0 for addu, addiu and every other word.
- R9: syscall (opcode 0x00, funct 0x0C) sets only `syscall_o` among the strobes.
- R10: With opcode 0x10: rs 0x00 is mfc0 (`cp0_rd_o`=1, `reg_wr_o`=1, `reg_dst_o`=0). rs 0x04 is mtc0 (`cp0_wr_o`=1). rs bit 4 set together with funct 0x18 is eret (`eret_o`=1).
- R11: Any other opcode, any other funct under opcode 0x00, or any other opcode-0x10 form sets `illegal_o`=1. All other outputs then take their idle values: strobes 0, ALU code 0, `reg_dst_o`=0, `sign_ext_o`=1.
- R12: At most one of these is active for any word: memory read, memory write, branch, jump, syscall, cp0 read, cp0 write, eret.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_i | input | 32 | Instruction word |
| alu_op_o | output | 4 | ALU operation code |
| alu_src_imm_o | output | 1 | Second ALU operand is the extended immediate |
| shamt_src_o | output | 1 | Shift amount comes from the shamt field |
| reg_dst_o | output | 2 | Write-back register: 0 rt, 1 rd, 2 register 31 |
| reg_wr_o | output | 1 | Register file write enable |
| mem_rd_o | output | 1 | Data memory read |
| mem_wr_o | output | 1 | Data memory write |
| branch_o | output | 2 | 0 none, 1 taken on equal, 2 taken on not equal |
| jump_o | output | 2 | 0 none, 1 to target field, 2 to rs |
| link_o | output | 1 | Write PC+4 as the result |
| sign_ext_o | output | 1 | 1 sign-extend, 0 zero-extend the immediate |
| ovf_trap_o | output | 1 | Signed overflow must raise a trap |
| syscall_o | output | 1 | System-call trap |
| cp0_rd_o | output | 1 | Move from coprocessor 0 |
| cp0_wr_o | output | 1 | Move to coprocessor 0 |
| eret_o | output | 1 | Exception return |
| illegal_o | output | 1 | Word is outside the subset |

## Verification
The assertions assume the instruction word is a settled two-state value whenever they are evaluated. They do not assume the word is legal, because illegal words are part of the checked space. The bench drives words only at rising edges and reads the outputs at falling edges, so every word it applies is fully defined. Fields the decoder ignores (rs for shifts, rt/rd for jumps, the immediates) are filled with random values, which shows that those bits have no effect on the outputs.

// File: rtl/icd_pkg.sv
package icd_pkg;
  localparam int unsigned INSTR_W = 32;
  localparam int unsigned OPC_W   = 6;
  localparam int unsigned FN_W    = 6;
  localparam int unsigned REG_W   = 5;
  localparam int unsigned OPC_LSB = INSTR_W - OPC_W;
  localparam int unsigned RS_LSB  = OPC_LSB - REG_W;

  // opcode values (decode depends on them)
  localparam logic [OPC_W-1:0] OPC_SPECIAL = 6'h00;
  localparam logic [OPC_W-1:0] OPC_J       = 6'h02;
  localparam logic [OPC_W-1:0] OPC_JAL     = 6'h03;
  localparam logic [OPC_W-1:0] OPC_BEQ     = 6'h04;
  localparam logic [OPC_W-1:0] OPC_BNE     = 6'h05;
  localparam logic [OPC_W-1:0] OPC_ADDI    = 6'h08;
  localparam logic [OPC_W-1:0] OPC_ADDIU   = 6'h09;
  localparam logic [OPC_W-1:0] OPC_SLTI    = 6'h0A;
  localparam logic [OPC_W-1:0] OPC_ANDI    = 6'h0C;
  localparam logic [OPC_W-1:0] OPC_ORI     = 6'h0D;
  localparam logic [OPC_W-1:0] OPC_COP0    = 6'h10;
  localparam logic [OPC_W-1:0] OPC_LW      = 6'h23;
  localparam logic [OPC_W-1:0] OPC_SW      = 6'h2B;

  // funct values under OPC_SPECIAL
  localparam logic [FN_W-1:0] FN_SLL  = 6'h00;
  localparam logic [FN_W-1:0] FN_SRL  = 6'h02;
  localparam logic [FN_W-1:0] FN_SRA  = 6'h03;
  localparam logic [FN_W-1:0] FN_JR   = 6'h08;
  localparam logic [FN_W-1:0] FN_SYS  = 6'h0C;
  localparam logic [FN_W-1:0] FN_ADD  = 6'h20;
  localparam logic [FN_W-1:0] FN_ADDU = 6'h21;
  localparam logic [FN_W-1:0] FN_SUB  = 6'h22;
  localparam logic [FN_W-1:0] FN_AND  = 6'h24;
  localparam logic [FN_W-1:0] FN_OR   = 6'h25;
  localparam logic [FN_W-1:0] FN_NOR  = 6'h27;
  localparam logic [FN_W-1:0] FN_SLT  = 6'h2A;
  localparam logic [FN_W-1:0] FN_SLTU = 6'h2B;

  // coprocessor-0 forms
  localparam logic [REG_W-1:0] CP_MF   = 5'h00;
  localparam logic [REG_W-1:0] CP_MT   = 5'h04;
  localparam logic [FN_W-1:0]  FN_ERET = 6'h18;

  typedef enum logic [3:0] {
    ALU_ADD  = 4'd0, ALU_SUB = 4'd1, ALU_AND = 4'd2, ALU_OR  = 4'd3,
    ALU_NOR  = 4'd4, ALU_SLT = 4'd5, ALU_SLTU = 4'd6,
    ALU_SLL  = 4'd7, ALU_SRL = 4'd8, ALU_SRA = 4'd9
  } alu_op_e;

  typedef enum logic [1:0] {DST_RT = 2'd0, DST_RD = 2'd1, DST_RA = 2'd2} dst_e;
  typedef enum logic [1:0] {BR_NONE = 2'd0, BR_EQ = 2'd1, BR_NE = 2'd2} br_e;
  typedef enum logic [1:0] {JMP_NONE = 2'd0, JMP_TGT = 2'd1, JMP_REG = 2'd2} jmp_e;

  typedef struct packed {
    alu_op_e alu_op;
    logic    alu_src_imm;
    logic    shamt_src;
    dst_e    reg_dst;
    logic    reg_wr;
    logic    mem_rd;
    logic    mem_wr;
    br_e     branch;
    jmp_e    jump;
    logic    link;
    logic    sign_ext;
    logic    ovf_trap;
    logic    syscall;
    logic    cp0_rd;
    logic    cp0_wr;
    logic    eret;
  } ctrl_t;

  function automatic ctrl_t ctrl_idle();
    ctrl_t c;
    c = '0;
    c.alu_op   = ALU_ADD;
    c.reg_dst  = DST_RT;
    c.branch   = BR_NONE;
    c.jump     = JMP_NONE;
    c.sign_ext = 1'b1;
    return c;
  endfunction

  // register-writing ALU form
  function automatic ctrl_t ctrl_alu(alu_op_e op, dst_e dst, logic imm, logic trap);
    ctrl_t c;
    c = ctrl_idle();
    c.alu_op      = op;
    c.reg_dst     = dst;
    c.reg_wr      = 1'b1;
    c.alu_src_imm = imm;
    c.ovf_trap    = trap;
    return c;
  endfunction

  function automatic logic is_shift_op(alu_op_e op);
    return (op == ALU_SLL) || (op == ALU_SRL) || (op == ALU_SRA);
  endfunction

  function automatic logic is_signed_arith(alu_op_e op);
    return (op == ALU_ADD) || (op == ALU_SUB);
  endfunction
endpackage

// File: rtl/icd_special_dec.sv
module icd_special_dec
  import icd_pkg::*;
(
  input  logic [FN_W-1:0] funct_i,
  output ctrl_t           ctrl_o,
  output logic            hit_o
);
  always_comb begin
    ctrl_o = ctrl_idle();
    hit_o  = 1'b1;
    unique case (funct_i)
      FN_ADD:  ctrl_o = ctrl_alu(ALU_ADD,  DST_RD, 1'b0, 1'b1);
      FN_ADDU: ctrl_o = ctrl_alu(ALU_ADD,  DST_RD, 1'b0, 1'b0);
      FN_SUB:  ctrl_o = ctrl_alu(ALU_SUB,  DST_RD, 1'b0, 1'b1);
      FN_AND:  ctrl_o = ctrl_alu(ALU_AND,  DST_RD, 1'b0, 1'b0);
      FN_OR:   ctrl_o = ctrl_alu(ALU_OR,   DST_RD, 1'b0, 1'b0);
      FN_NOR:  ctrl_o = ctrl_alu(ALU_NOR,  DST_RD, 1'b0, 1'b0);
      FN_SLT:  ctrl_o = ctrl_alu(ALU_SLT,  DST_RD, 1'b0, 1'b0);
      FN_SLTU: ctrl_o = ctrl_alu(ALU_SLTU, DST_RD, 1'b0, 1'b0);
      FN_SLL, FN_SRL, FN_SRA: begin
        ctrl_o = ctrl_alu(funct_i == FN_SLL ? ALU_SLL :
                          funct_i == FN_SRL ? ALU_SRL : ALU_SRA,
                          DST_RD, 1'b0, 1'b0);
        ctrl_o.shamt_src = 1'b1;
      end
      FN_JR:   ctrl_o.jump    = JMP_REG;
      FN_SYS:  ctrl_o.syscall = 1'b1;
      default: hit_o = 1'b0;
    endcase
  end

  // R2: every shift form takes its amount from the shamt field
  always_comb begin
    if (hit_o && is_shift_op(ctrl_o.alu_op))
      AST_SHIFT_AMOUNT: assert (ctrl_o.shamt_src && ctrl_o.reg_dst == DST_RD); // R2
  end
endmodule

// File: rtl/icd_main_dec.sv
module icd_main_dec
  import icd_pkg::*;
(
  input  logic [OPC_W-1:0] opc_i,
  output ctrl_t            ctrl_o,
  output logic             hit_o
);
  always_comb begin
    ctrl_o = ctrl_idle();
    hit_o  = 1'b1;
    unique case (opc_i)
      OPC_ADDI:  ctrl_o = ctrl_alu(ALU_ADD, DST_RT, 1'b1, 1'b1);
      OPC_ADDIU: ctrl_o = ctrl_alu(ALU_ADD, DST_RT, 1'b1, 1'b0);
      OPC_SLTI:  ctrl_o = ctrl_alu(ALU_SLT, DST_RT, 1'b1, 1'b0);
      OPC_ANDI, OPC_ORI: begin
        ctrl_o = ctrl_alu(opc_i == OPC_ANDI ? ALU_AND : ALU_OR, DST_RT, 1'b1, 1'b0);
        ctrl_o.sign_ext = 1'b0;
      end
      OPC_LW: begin
        ctrl_o = ctrl_alu(ALU_ADD, DST_RT, 1'b1, 1'b0);
        ctrl_o.mem_rd = 1'b1;
      end
      OPC_SW: begin
        ctrl_o.alu_src_imm = 1'b1;
        ctrl_o.mem_wr      = 1'b1;
      end
      OPC_BEQ, OPC_BNE: begin
        ctrl_o.alu_op = ALU_SUB;
        ctrl_o.branch = (opc_i == OPC_BEQ) ? BR_EQ : BR_NE;
      end
      OPC_J:   ctrl_o.jump = JMP_TGT;
      OPC_JAL: begin
        ctrl_o.jump    = JMP_TGT;
        ctrl_o.link    = 1'b1;
        ctrl_o.reg_wr  = 1'b1;
        ctrl_o.reg_dst = DST_RA;
      end
      default: hit_o = 1'b0;
    endcase
  end

  // R4: zero extension only ever pairs with an immediate logic operation
  always_comb begin
    if (hit_o && !ctrl_o.sign_ext)
      AST_ZERO_EXT_LOGIC: assert (ctrl_o.alu_src_imm && (ctrl_o.alu_op == ALU_AND || ctrl_o.alu_op == ALU_OR)); // R4
  end
endmodule

// File: rtl/icd_cop0_dec.sv
module icd_cop0_dec
  import icd_pkg::*;
(
  input  logic [REG_W-1:0] rs_i,
  input  logic [FN_W-1:0]  funct_i,
  output ctrl_t            ctrl_o,
  output logic             hit_o
);
  logic is_mf, is_mt, is_ret;

  assign is_mf  = (rs_i == CP_MF);
  assign is_mt  = (rs_i == CP_MT);
  assign is_ret = rs_i[REG_W-1] && (funct_i == FN_ERET);

  always_comb begin
    ctrl_o = ctrl_idle();
    hit_o  = is_mf || is_mt || is_ret;
    if (is_mf) begin
      ctrl_o.cp0_rd  = 1'b1;
      ctrl_o.reg_wr  = 1'b1;
      ctrl_o.reg_dst = DST_RT;
    end
    if (is_mt)  ctrl_o.cp0_wr = 1'b1;
    if (is_ret) ctrl_o.eret   = 1'b1;
  end

  // R10: the three coprocessor forms are mutually exclusive
  always_comb begin
    AST_COP0_FORM: assert ($onehot0({is_mf, is_mt, is_ret})); // R10
  end
endmodule

// File: rtl/insn_ctrl_decode.sv
module insn_ctrl_decode
  import icd_pkg::*;
(
  input  logic [31:0] instr_i,
  output logic [3:0]  alu_op_o,
  output logic        alu_src_imm_o,
  output logic        shamt_src_o,
  output logic [1:0]  reg_dst_o,
  output logic        reg_wr_o,
  output logic        mem_rd_o,
  output logic        mem_wr_o,
  output logic [1:0]  branch_o,
  output logic [1:0]  jump_o,
  output logic        link_o,
  output logic        sign_ext_o,
  output logic        ovf_trap_o,
  output logic        syscall_o,
  output logic        cp0_rd_o,
  output logic        cp0_wr_o,
  output logic        eret_o,
  output logic        illegal_o
);
  logic [OPC_W-1:0] opc;
  logic [REG_W-1:0] rs;
  logic [FN_W-1:0]  funct;
  logic             unused_fields;

  assign opc           = instr_i[INSTR_W-1:OPC_LSB];
  assign rs            = instr_i[OPC_LSB-1:RS_LSB];
  assign funct         = instr_i[FN_W-1:0];
  assign unused_fields = ^instr_i[RS_LSB-1:FN_W];

  ctrl_t sp_ctrl, mn_ctrl, c0_ctrl, sel_ctrl, out_ctrl;
  logic  sp_hit, mn_hit, c0_hit, sel_hit;

  icd_special_dec u_special (.funct_i(funct), .ctrl_o(sp_ctrl), .hit_o(sp_hit));
  icd_main_dec    u_main    (.opc_i(opc), .ctrl_o(mn_ctrl), .hit_o(mn_hit));
  icd_cop0_dec    u_cop0    (.rs_i(rs), .funct_i(funct), .ctrl_o(c0_ctrl), .hit_o(c0_hit));

  always_comb begin
    if (opc == OPC_SPECIAL) begin
      sel_ctrl = sp_ctrl; sel_hit = sp_hit;
    end else if (opc == OPC_COP0) begin
      sel_ctrl = c0_ctrl; sel_hit = c0_hit;
    end else begin
      sel_ctrl = mn_ctrl; sel_hit = mn_hit;
    end
    out_ctrl = sel_hit ? sel_ctrl : ctrl_idle();
  end

  assign illegal_o     = !sel_hit;
  assign alu_op_o      = out_ctrl.alu_op;
  assign alu_src_imm_o = out_ctrl.alu_src_imm;
  assign shamt_src_o   = out_ctrl.shamt_src;
  assign reg_dst_o     = out_ctrl.reg_dst;
  assign reg_wr_o      = out_ctrl.reg_wr;
  assign mem_rd_o      = out_ctrl.mem_rd;
  assign mem_wr_o      = out_ctrl.mem_wr;
  assign branch_o      = out_ctrl.branch;
  assign jump_o        = out_ctrl.jump;
  assign link_o        = out_ctrl.link;
  assign sign_ext_o    = out_ctrl.sign_ext;
  assign ovf_trap_o    = out_ctrl.ovf_trap;
  assign syscall_o     = out_ctrl.syscall;
  assign cp0_rd_o      = out_ctrl.cp0_rd;
  assign cp0_wr_o      = out_ctrl.cp0_wr;
  assign eret_o        = out_ctrl.eret;

  always_comb begin
    if (illegal_o)
      AST_ILLEGAL_QUIET: assert (!reg_wr_o && !mem_wr_o && !mem_rd_o && !cp0_wr_o && branch_o == 2'd0 && jump_o == 2'd0 && !syscall_o && !eret_o && !ovf_trap_o); // R11
    AST_ONE_EFFECT: assert ($onehot0({mem_rd_o, mem_wr_o, branch_o != 2'd0, jump_o != 2'd0, syscall_o, cp0_rd_o, cp0_wr_o, eret_o})); // R12
    if (link_o)
      AST_LINK_RA: assert (reg_dst_o == 2'd2 && reg_wr_o && jump_o == 2'd1); // R7
    if (mem_wr_o)
      AST_STORE_NO_WB: assert (!reg_wr_o && alu_src_imm_o); // R5
    if (ovf_trap_o)
      AST_TRAP_ARITH: assert (is_signed_arith(alu_op_e'(alu_op_o)) && reg_wr_o && !illegal_o); // R8
  end
endmodule

// File: tb/insn_ctrl_decode_tb.sv
module insn_ctrl_decode_tb;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [3:0] alu; logic imm; logic sh; logic [1:0] dst; logic wr;
    logic mrd; logic mwr; logic [1:0] br; logic [1:0] jmp; logic lnk;
    logic sext; logic ovf; logic sys; logic crd; logic cwr; logic ret; logic ill;
  } exp_t;

  typedef enum int {
    M_ADD, M_ADDU, M_SUB, M_AND, M_OR, M_NOR, M_SLT, M_SLTU,
    M_SLL, M_SRL, M_SRA, M_JR, M_SYS,
    M_ADDI, M_ADDIU, M_SLTI, M_ANDI, M_ORI, M_LW, M_SW, M_BEQ, M_BNE,
    M_J, M_JAL, M_MFC0, M_MTC0, M_ERET
  } mn_e;

  logic clk = 1'b0;
  logic [31:0] instr = 32'h0;
  exp_t act;
  int n_chk = 0, n_fail = 0;
  bit done = 0;
  exp_t  q_exp[$];
  string q_req[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  insn_ctrl_decode u_dut (
    .instr_i(instr), .alu_op_o(act.alu), .alu_src_imm_o(act.imm),
    .shamt_src_o(act.sh), .reg_dst_o(act.dst), .reg_wr_o(act.wr),
    .mem_rd_o(act.mrd), .mem_wr_o(act.mwr), .branch_o(act.br),
    .jump_o(act.jmp), .link_o(act.lnk), .sign_ext_o(act.sext),
    .ovf_trap_o(act.ovf), .syscall_o(act.sys), .cp0_rd_o(act.crd),
    .cp0_wr_o(act.cwr), .eret_o(act.ret), .illegal_o(act.ill)
  );

  function automatic exp_t idle();
    exp_t e = '0;
    e.sext = 1'b1;
    return e;
  endfunction

  function automatic exp_t wb(logic [3:0] alu, logic [1:0] dst, logic imm);
    exp_t e = idle();
    e.alu = alu; e.dst = dst; e.wr = 1'b1; e.imm = imm;
    return e;
  endfunction

  // expected control values written from the requirement text
  function automatic exp_t expect_of(mn_e m);
    exp_t e = idle();
    case (m)
      M_ADD:   begin e = wb(4'd0, 2'd1, 0); e.ovf = 1; end
      M_ADDU:  e = wb(4'd0, 2'd1, 0);
      M_SUB:   begin e = wb(4'd1, 2'd1, 0); e.ovf = 1; end
      M_AND:   e = wb(4'd2, 2'd1, 0);
      M_OR:    e = wb(4'd3, 2'd1, 0);
      M_NOR:   e = wb(4'd4, 2'd1, 0);
      M_SLT:   e = wb(4'd5, 2'd1, 0);
      M_SLTU:  e = wb(4'd6, 2'd1, 0);
      M_SLL:   begin e = wb(4'd7, 2'd1, 0); e.sh = 1; end
      M_SRL:   begin e = wb(4'd8, 2'd1, 0); e.sh = 1; end
      M_SRA:   begin e = wb(4'd9, 2'd1, 0); e.sh = 1; end
      M_JR:    e.jmp = 2'd2;
      M_SYS:   e.sys = 1;
      M_ADDI:  begin e = wb(4'd0, 2'd0, 1); e.ovf = 1; end
      M_ADDIU: e = wb(4'd0, 2'd0, 1);
      M_SLTI:  e = wb(4'd5, 2'd0, 1);
      M_ANDI:  begin e = wb(4'd2, 2'd0, 1); e.sext = 0; end
      M_ORI:   begin e = wb(4'd3, 2'd0, 1); e.sext = 0; end
      M_LW:    begin e = wb(4'd0, 2'd0, 1); e.mrd = 1; end
      M_SW:    begin e.imm = 1; e.mwr = 1; end
      M_BEQ:   begin e.alu = 4'd1; e.br = 2'd1; end
      M_BNE:   begin e.alu = 4'd1; e.br = 2'd2; end
      M_J:     e.jmp = 2'd1;
      M_JAL:   begin e.jmp = 2'd1; e.lnk = 1; e.wr = 1; e.dst = 2'd2; end
      M_MFC0:  begin e.crd = 1; e.wr = 1; end
      M_MTC0:  e.cwr = 1;
      M_ERET:  e.ret = 1;
      default: e = idle();
    endcase
    return e;
  endfunction

  function automatic string req_of(mn_e m);
    case (m)
      M_ADD, M_SUB, M_ADDI:                    return "R8";
      M_ADDU, M_AND, M_OR, M_NOR, M_SLT, M_SLTU: return "R1";
      M_SLL, M_SRL, M_SRA:                     return "R2";
      M_ADDIU, M_SLTI:                         return "R3";
      M_ANDI, M_ORI:                           return "R4";
      M_LW, M_SW:                              return "R5";
      M_BEQ, M_BNE:                            return "R6";
      M_J, M_JAL, M_JR:                        return "R7";
      M_SYS:                                   return "R9";
      default:                                 return "R10";
    endcase
  endfunction

  function automatic logic [31:0] rtype(logic [5:0] fn);
    return {6'h00, 20'($urandom), fn};
  endfunction

  function automatic logic [31:0] itype(logic [5:0] op);
    return {op, 26'($urandom)};
  endfunction

  function automatic logic [31:0] encode(mn_e m);
    case (m)
      M_ADD:   return rtype(6'h20);
      M_ADDU:  return rtype(6'h21);
      M_SUB:   return rtype(6'h22);
      M_AND:   return rtype(6'h24);
      M_OR:    return rtype(6'h25);
      M_NOR:   return rtype(6'h27);
      M_SLT:   return rtype(6'h2A);
      M_SLTU:  return rtype(6'h2B);
      M_SLL:   return rtype(6'h00);
      M_SRL:   return rtype(6'h02);
      M_SRA:   return rtype(6'h03);
      M_JR:    return rtype(6'h08);
      M_SYS:   return rtype(6'h0C);
      M_ADDI:  return itype(6'h08);
      M_ADDIU: return itype(6'h09);
      M_SLTI:  return itype(6'h0A);
      M_ANDI:  return itype(6'h0C);
      M_ORI:   return itype(6'h0D);
      M_LW:    return itype(6'h23);
      M_SW:    return itype(6'h2B);
      M_BEQ:   return itype(6'h04);
      M_BNE:   return itype(6'h05);
      M_J:     return itype(6'h02);
      M_JAL:   return itype(6'h03);
      M_MFC0:  return {6'h10, 5'h00, 10'($urandom), 11'h0};
      M_MTC0:  return {6'h10, 5'h04, 10'($urandom), 11'h0};
      default: return {6'h10, 5'h10, 15'h0, 6'h18};
    endcase
  endfunction

  task automatic push(input logic [31:0] w, input exp_t e, input string r);
    @(posedge clk);
    instr = w;
    q_exp.push_back(e);
    q_req.push_back(r);
  endtask

  // monitor: compare at the falling edge after each applied word
  initial begin
    forever begin
      @(negedge clk);
      if (q_exp.size() != 0) begin
        exp_t e;
        string r;
        e = q_exp.pop_front();
        r = q_req.pop_front();
        n_chk++;
        if (act !== e) begin
          n_fail++;
          $display("FAIL %s instr=%h got=%h exp=%h", r, instr, act, e);
        end
        n_chk++; // R12 exclusivity of side-effect classes
        if (!$onehot0({act.mrd, act.mwr, act.br != 2'd0, act.jmp != 2'd0,
                       act.sys, act.crd, act.cwr, act.ret})) begin
          n_fail++;
          $display("FAIL R12 instr=%h got=%h exp=at most one effect", instr, act);
        end
      end
    end
  end

  initial begin
    exp_t ill;
    ill = idle();
    ill.ill = 1'b1;
    // initial word 0 decodes as sll (R2)
    push(32'h0000_0000, expect_of(M_SLL), "R2");
    for (int rep = 0; rep < 20; rep++) begin
      for (int k = 0; k <= int'(M_ERET); k++) begin
        mn_e m = mn_e'(k);
        push(encode(m), expect_of(m), req_of(m));
      end
    end
    // R11: words outside the subset
    for (int rep = 0; rep < 10; rep++) begin
      push({6'h01, 26'($urandom)}, ill, "R11");
      push({6'h3F, 26'($urandom)}, ill, "R11");
      push({6'h0E, 26'($urandom)}, ill, "R11");
      push({6'h20, 26'($urandom)}, ill, "R11");
      push({6'h00, 20'($urandom), 6'h01}, ill, "R11");
      push({6'h00, 20'($urandom), 6'h26}, ill, "R11");
      push({6'h10, 5'h02, 21'($urandom)}, ill, "R11");
      push({6'h10, 5'h10, 15'($urandom), 6'h01}, ill, "R11");
    end
    // R1/R4: legal word after an illegal one recovers fully
    push(encode(M_ANDI), expect_of(M_ANDI), "R4");
    push({6'h01, 26'h0}, ill, "R11");
    push(encode(M_ADDU), expect_of(M_ADDU), "R1");
    repeat (3) @(posedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule